// File: doc/BRIEF.md
# Radix Page-Table Walker

The walker turns an effective address into a real address by stepping down a radix tree of page tables held in memory. A caller supplies the effective address, the base address of the root table, the root table's index width, and the width of the whole address space, all as log2 values. The caller then pulses a start input. The walker reads one 64-bit entry per level through a request/valid read port. At each level it checks the entry and either goes down to the next table or stops at a leaf.

Each table sets the index width of the level below it. The page size that a leaf maps is what is left of the address-space width after every level's index width has been subtracted. A leaf produces the real address, the page size, the leaf entry and the address where that entry was found. Both outcomes end with a one-cycle done pulse. A walk that cannot finish ends with a fault cause instead. A level that is too narrow, too wide or too deep is a configuration fault. An entry marked not valid is a missing-entry fault.

Top module: `radix_walker`

## Requirements
- R1: After reset, busy_o, rd_req_o and done_o are low.
- R2: If the root index width is below 5, the walk ends with cause 1 (bad configuration) and no memory read is made.
- R3: The read address for a level is base + 8 × ((EA >> (remaining − width)) masked to width bits). rd_addr_o stays stable while rd_req_o waits for rd_valid_i.
- R4: An entry whose bit 63 (valid) is clear ends the walk with cause 2 (no entry).
- R5: A valid entry whose bit 62 (leaf) is clear is a directory entry. The next index width is taken from entry bits 4:0, the next table base is entry bits 55:8 with bits 7:0 zero, and the walk continues.
- R6: After each valid entry the remaining width is reduced by that level's index width. At a leaf, page_bits_o reports the remaining width.
- R7: At a leaf, mask = (1 << page_bits) − 1. real_addr_o = (entry AND 0x00FF_FFFF_FFFF_F000 AND NOT mask) OR (EA AND mask), so entry bits 63:56 and 11:0 never reach the address.
- R8: On success (cause 0) leaf_entry_o holds the leaf entry and leaf_addr_o holds the address it was read from.
- R9: The width check is repeated before every later read. A directory entry that gives a width below 5 ends the walk with cause 1 and no further read.
- R10: At most MAX_DEPTH reads are made per walk. If the walk would need a read beyond that, it ends with cause 1.
- R11: done_o is a single-cycle pulse that ends busy_o. start_i is taken only while the walker is idle; a start during a walk has no effect on that walk's results.
- R12: An index width larger than the remaining width ends the walk with cause 1 before that read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| ea_i | input | 64 | Effective address to translate |
| root_base_i | input | 64 | Base address of the root table |
| root_lvl_bits_i | input | 5 | log2 of the root table's entry count |
| space_bits_i | input | 7 | log2 of the whole address space |
| busy_o | output | 1 | A walk is in progress |
| rd_req_o | output | 1 | Memory read request, held until rd_valid_i |
| rd_addr_o | output | 64 | Address of the entry being read |
| rd_valid_i | input | 1 | Read data is present this cycle |
| rd_data_i | input | 64 | Entry read from memory |
| done_o | output | 1 | One-cycle pulse at the end of a walk |
| cause_o | output | 2 | 0 success, 1 bad configuration, 2 no entry |
| real_addr_o | output | 64 | Translated real address (success only) |
| page_bits_o | output | 7 | log2 of the mapped page size (success only) |
| leaf_entry_o | output | 64 | Leaf entry found (success only) |
| leaf_addr_o | output | 64 | Address of the leaf entry (success only) |

## Verification
The assertions check the following on every cycle:
- a request is never raised while idle, and its address holds until the reply arrives;
- done is a lone pulse that returns the walker to idle;
- an invalid reply ends the walk with cause 2 on the next cycle, and a leaf reply ends it with success;
- a failed width or depth check ends the walk with cause 1 without a read;
- the level count never exceeds the depth limit.

Only the bench scenarios can show that the arithmetic is right:
- the index placement at each width;
- the page size left after three, four or one level;
- the real address built from page number and offset, with attribute bits ignored;
- the exact read counts for each kind of fault;
- that a start given during a walk leaves its results untouched.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;
  localparam int unsigned AW           = 64;  // address and entry width
  localparam int unsigned SZW          = 7;   // width of a log2 size
  localparam int unsigned LBW          = 5;   // width of a level index size
  localparam int unsigned MIN_LVL_BITS = 5;   // narrowest legal table
  localparam int unsigned V_BIT        = 63;
  localparam int unsigned L_BIT        = 62;
  localparam logic [AW-1:0] NEXT_BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [AW-1:0] PAGE_NUM_MASK  = 64'h00FF_FFFF_FFFF_F000;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BADCFG = 2'd1,
    CAUSE_NOENT  = 2'd2
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;

  // Address of the slot that EA selects in a table of 2**lvl entries.
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                              input logic [AW-1:0] ea,
                                              input logic [SZW-1:0] remain,
                                              input logic [LBW-1:0] lvl);
    logic [AW-1:0] idx;
    idx = (ea >> (remain - SZW'(lvl))) & ((AW'(1) << lvl) - AW'(1));
    return base + (idx << 3);
  endfunction

  // Offset mask for a page of 2**remain bytes; a shift past the width gives all ones.
  function automatic logic [AW-1:0] low_mask(input logic [SZW-1:0] remain);
    return (AW'(1) << remain) - AW'(1);
  endfunction

  function automatic logic [AW-1:0] leaf_real(input logic [AW-1:0] entry,
                                              input logic [AW-1:0] ea,
                                              input logic [SZW-1:0] remain);
    logic [AW-1:0] m;
    m = low_mask(remain);
    return (entry & PAGE_NUM_MASK & ~m) | (ea & m);
  endfunction
endpackage

// File: rtl/rwalk_index.sv
module rwalk_index
  import rwalk_pkg::*;
(
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  ea_i,
  input  logic [SZW-1:0] remain_i,
  input  logic [LBW-1:0] lvl_bits_i,
  output logic [AW-1:0]  slot_o
);
  assign slot_o = slot_addr(base_i, ea_i, remain_i, lvl_bits_i);
endmodule

// File: rtl/rwalk_leaf.sv
module rwalk_leaf
  import rwalk_pkg::*;
(
  input  logic [AW-1:0]  entry_i,
  input  logic [AW-1:0]  ea_i,
  input  logic [SZW-1:0] remain_i,
  output logic [AW-1:0]  real_o
);
  assign real_o = leaf_real(entry_i, ea_i, remain_i);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rwalk_pkg::*;
#(
  parameter int unsigned MAX_DEPTH = 4,
  localparam int unsigned LVL_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [AW-1:0]  ea_i,
  input  logic [AW-1:0]  root_base_i,
  input  logic [LBW-1:0] root_lvl_bits_i,
  input  logic [SZW-1:0] space_bits_i,
  output logic           busy_o,
  output logic           rd_req_o,
  output logic [AW-1:0]  rd_addr_o,
  input  logic           rd_valid_i,
  input  logic [AW-1:0]  rd_data_i,
  output logic           done_o,
  output logic [1:0]     cause_o,
  output logic [AW-1:0]  real_addr_o,
  output logic [SZW-1:0] page_bits_o,
  output logic [AW-1:0]  leaf_entry_o,
  output logic [AW-1:0]  leaf_addr_o
);
  st_e             state_q;
  logic [AW-1:0]   ea_q, base_q, addr_q;
  logic [AW-1:0]   raddr_q, leaf_q, leaf_addr_q;
  logic [LBW-1:0]  lvlbits_q;
  logic [SZW-1:0]  remain_q, page_q;
  logic [LVL_W-1:0] lvl_cnt;
  logic            done_q;
  cause_e          cause_q;

  // Named internal events
  logic            start_take, in_check, size_bad, depth_hit, resp_take;
  logic            ent_valid, ent_leaf;
  logic [SZW-1:0]  remain_next;
  logic [AW-1:0]   slot_next, leaf_raddr;

  assign start_take  = start_i && (state_q == ST_IDLE);
  assign in_check    = (state_q == ST_CHECK);
  assign size_bad    = (lvlbits_q < LBW'(MIN_LVL_BITS)) || (SZW'(lvlbits_q) > remain_q);
  assign depth_hit   = (lvl_cnt == LVL_W'(MAX_DEPTH));
  assign resp_take   = (state_q == ST_WAIT) && rd_valid_i;
  assign ent_valid   = rd_data_i[V_BIT];
  assign ent_leaf    = rd_data_i[L_BIT];
  assign remain_next = remain_q - SZW'(lvlbits_q);

  rwalk_index u_index (
    .base_i     (base_q),
    .ea_i       (ea_q),
    .remain_i   (remain_q),
    .lvl_bits_i (lvlbits_q),
    .slot_o     (slot_next)
  );

  rwalk_leaf u_leaf (
    .entry_i  (rd_data_i),
    .ea_i     (ea_q),
    .remain_i (remain_next),
    .real_o   (leaf_raddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ea_q        <= '0;
      base_q      <= '0;
      addr_q      <= '0;
      raddr_q     <= '0;
      leaf_q      <= '0;
      leaf_addr_q <= '0;
      lvlbits_q   <= '0;
      remain_q    <= '0;
      page_q      <= '0;
      lvl_cnt     <= '0;
      done_q      <= 1'b0;
      cause_q     <= CAUSE_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_take) begin
            ea_q      <= ea_i;
            base_q    <= root_base_i;
            lvlbits_q <= root_lvl_bits_i;
            remain_q  <= space_bits_i;
            lvl_cnt   <= '0;
            state_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (depth_hit || size_bad) begin
            done_q  <= 1'b1;
            cause_q <= CAUSE_BADCFG;
            state_q <= ST_IDLE;
          end else begin
            addr_q  <= slot_next;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (resp_take) begin
            lvl_cnt <= lvl_cnt + LVL_W'(1);
            if (!ent_valid) begin
              done_q  <= 1'b1;
              cause_q <= CAUSE_NOENT;
              state_q <= ST_IDLE;
            end else begin
              remain_q <= remain_next;
              if (ent_leaf) begin
                done_q      <= 1'b1;
                cause_q     <= CAUSE_NONE;
                raddr_q     <= leaf_raddr;
                page_q      <= remain_next;
                leaf_q      <= rd_data_i;
                leaf_addr_q <= addr_q;
                state_q     <= ST_IDLE;
              end else begin
                lvlbits_q <= rd_data_i[LBW-1:0];
                base_q    <= rd_data_i & NEXT_BASE_MASK;
                state_q   <= ST_CHECK;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign rd_req_o     = (state_q == ST_WAIT);
  assign rd_addr_o    = addr_q;
  assign done_o       = done_q;
  assign cause_o      = cause_q;
  assign real_addr_o  = raddr_q;
  assign page_bits_o  = page_q;
  assign leaf_entry_o = leaf_q;
  assign leaf_addr_o  = leaf_addr_q;
endmodule

// File: rtl/rwalk_checker.sv
module rwalk_checker #(
  parameter int unsigned MAX_DEPTH = 4,
  parameter int unsigned LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             rd_req_o,
  input logic [63:0]      rd_addr_o,
  input logic             rd_valid_i,
  input logic [63:0]      rd_data_i,
  input logic             done_o,
  input logic [1:0]       cause_o,
  input logic [63:0]      leaf_entry_o,
  input logic [LVL_W-1:0] lvl_cnt,
  input logic             in_check,
  input logic             size_bad,
  input logic             depth_hit
);
  a_r1_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r4_invalid_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_valid_i && !rd_data_i[63]) |=> (done_o && cause_o == 2'd2));

  a_r7_leaf_succeeds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_valid_i && rd_data_i[63] && rd_data_i[62]) |=> (done_o && cause_o == 2'd0));

  a_r8_leaf_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cause_o == 2'd0) |-> (leaf_entry_o[63] && leaf_entry_o[62]));

  a_r9_badcfg_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && (size_bad || depth_hit)) |=> (done_o && cause_o == 2'd1 && !rd_req_o));

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lvl_cnt) <= int'(MAX_DEPTH));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind radix_walker rwalk_checker #(.MAX_DEPTH(MAX_DEPTH), .LVL_W(LVL_W)) u_rwalk_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .rd_valid_i   (rd_valid_i),
  .rd_data_i    (rd_data_i),
  .done_o       (done_o),
  .cause_o      (cause_o),
  .leaf_entry_o (leaf_entry_o),
  .lvl_cnt      (lvl_cnt),
  .in_check     (in_check),
  .size_bad     (size_bad),
  .depth_hit    (depth_hit)
);

// File: tb/test_radix_walker.sv
module test_radix_walker;
  localparam int unsigned MAXD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] ea_i = '0, root_base_i = '0;
  logic [4:0]  root_lvl_bits_i = '0;
  logic [6:0]  space_bits_i = '0;
  logic        busy_o, rd_req_o, done_o;
  logic [63:0] rd_addr_o, real_addr_o, leaf_entry_o, leaf_addr_o;
  logic        rd_valid_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic [1:0]  cause_o;
  logic [6:0]  page_bits_o;

  always #10 clk = ~clk;  // 50 MHz

  radix_walker #(.MAX_DEPTH(MAXD)) i_radix_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ea_i(ea_i),
    .root_base_i(root_base_i), .root_lvl_bits_i(root_lvl_bits_i),
    .space_bits_i(space_bits_i), .busy_o(busy_o), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .cause_o(cause_o), .real_addr_o(real_addr_o),
    .page_bits_o(page_bits_o), .leaf_entry_o(leaf_entry_o), .leaf_addr_o(leaf_addr_o)
  );

  logic [63:0] mem [logic [63:0]];
  int          n_chk = 0, n_fail = 0, rd_count = 0;
  logic [63:0] first_addr = '0;
  bit          finished = 1'b0;

  typedef struct {
    string       tag;
    logic [1:0]  cause;
    int          reads;
    logic [63:0] first;
    logic [63:0] raddr;
    int          psz;
    logic [63:0] leaf;
    logic [63:0] laddr;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] peek(logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] tbl_slot(logic [63:0] base, logic [63:0] ea, int ps, int n);
    logic [63:0] sel;
    sel = ea >> (ps - n);
    sel = sel % (64'd1 << n);
    return base + sel * 64'd8;
  endfunction

  function automatic logic [63:0] mk_dir(logic [63:0] nb, int n);
    return {1'b1, 1'b0, 6'h00, nb[55:8], 3'b000, 5'(n)};
  endfunction

  // Leaf with junk in attribute bits that must not reach the address
  function automatic logic [63:0] mk_leaf(logic [63:0] pg);
    return {2'b11, 6'h2A, pg[55:12], 12'h5A5};
  endfunction

  task automatic put(logic [63:0] base, logic [63:0] ea, int ps, int n, logic [63:0] ent);
    mem[tbl_slot(base, ea, ps, n)] = ent;
  endtask

  function automatic exp_t ref_walk(logic [63:0] ea, logic [63:0] base, int n, int tsz);
    exp_t e;
    int ps = tsz;
    logic [63:0] a, ent, m;
    e.tag = ""; e.cause = 2'd0; e.reads = 0; e.first = '0;
    e.raddr = '0; e.psz = 0; e.leaf = '0; e.laddr = '0;
    for (int lv = 0; lv <= int'(MAXD); lv++) begin
      if (lv == int'(MAXD) || n < 5 || n > ps) begin
        e.cause = 2'd1; e.reads = lv; return e;
      end
      a = tbl_slot(base, ea, ps, n);
      if (lv == 0) e.first = a;
      ent = peek(a);
      e.reads = lv + 1;
      if (!ent[63]) begin e.cause = 2'd2; return e; end
      ps = ps - n;
      if (ent[62]) begin
        m = (ps >= 64) ? '1 : ((64'd1 << ps) - 64'd1);
        e.raddr = ((ent & 64'h00FF_FFFF_FFFF_F000) & ~m) | (ea & m);
        e.psz = ps; e.leaf = ent; e.laddr = a;
        return e;
      end
      n = int'(ent[4:0]);
      base = ent & 64'h00FF_FFFF_FFFF_FF00;
    end
    return e;
  endfunction

  task automatic launch(string tag, logic [63:0] ea, logic [63:0] base, int n, int tsz);
    exp_t e;
    e = ref_walk(ea, base, n, tsz);
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    rd_count = 0;
    ea_i = ea; root_base_i = base; root_lvl_bits_i = 5'(n); space_bits_i = 7'(tsz);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_walk(string tag, logic [63:0] ea, logic [63:0] base, int n, int tsz);
    launch(tag, ea, base, n, tsz);
    drain();
  endtask

  // Memory responder with varying latency
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req_o) begin
        if (rd_count == 0) first_addr = rd_addr_o;
        repeat (1 + (rd_count % 3)) @(negedge clk);
        rd_data_i  = peek(rd_addr_o);
        rd_valid_i = 1'b1;
        rd_count++;
        @(negedge clk);
        rd_valid_i = 1'b0;
      end
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(cause_o == e.cause, e.tag, "cause", 64'(cause_o), 64'(e.cause));
        chk(rd_count == e.reads, e.tag, "read count", 64'(rd_count), 64'(e.reads));
        if (e.reads > 0)
          chk(first_addr == e.first, e.tag, "first read address", first_addr, e.first);
        if (e.cause == 2'd0) begin
          chk(real_addr_o == e.raddr, e.tag, "real address", real_addr_o, e.raddr);
          chk(int'(page_bits_o) == e.psz, e.tag, "page bits", 64'(page_bits_o), 64'(e.psz));
          chk(leaf_entry_o == e.leaf, e.tag, "leaf entry", leaf_entry_o, e.leaf);
          chk(leaf_addr_o == e.laddr, e.tag, "leaf address", leaf_addr_o, e.laddr);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R11", "watchdog, walk never finished", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [63:0] EA1 = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] EA2 = 64'h000F_EDCB_A987_6543;
  localparam logic [63:0] EA3 = 64'h0008_8888_7777_6666;
  localparam logic [63:0] EA7 = 64'hA5A5_0F0F_3C3C_1234;

  initial begin
    // Tables
    put(64'h0010_0000, EA1, 52, 13, mk_dir(64'h0020_0000, 9));
    put(64'h0020_0000, EA1, 39, 9,  mk_dir(64'h0030_0000, 9));
    put(64'h0030_0000, EA1, 30, 9,  mk_leaf(64'h0000_00AB_CDE0_0000));

    put(64'h0040_0000, EA2, 52, 13, mk_dir(64'h0050_0000, 9));
    put(64'h0050_0000, EA2, 39, 9,  mk_dir(64'h0060_0000, 9));
    put(64'h0060_0000, EA2, 30, 9,  mk_dir(64'h0070_0000, 9));
    put(64'h0070_0000, EA2, 21, 9,  mk_leaf(64'h00F0_0012_3456_7000));

    put(64'h0080_0000, EA3, 52, 13, mk_leaf(64'h0012_3400_0000_0000));

    put(64'h0090_0000, EA1, 52, 13, mk_dir(64'h00A0_0000, 9));  // next level empty
    put(64'h00B0_0000, EA1, 52, 13, mk_dir(64'h00C0_0000, 3));  // too narrow

    put(64'h00D0_0000, EA7, 64, 5, mk_dir(64'h00E0_0000, 5));
    put(64'h00E0_0000, EA7, 59, 5, mk_dir(64'h00F0_0000, 5));
    put(64'h00F0_0000, EA7, 54, 5, mk_dir(64'h0100_0000, 5));
    put(64'h0100_0000, EA7, 49, 5, mk_dir(64'h0110_0000, 5));

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 1'b0, "R1", "busy after reset", 64'(busy_o), 64'd0);
    chk(rd_req_o == 1'b0, "R1", "request after reset", 64'(rd_req_o), 64'd0);
    chk(done_o == 1'b0, "R1", "done after reset", 64'(done_o), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0, "R1", "busy idle", 64'(busy_o), 64'd0);

    run_walk("R5 R8", EA1, 64'h0010_0000, 13, 52);                    // three levels, 2 MiB page
    run_walk("R3",    EA2, 64'h0040_0000, 13, 52);                    // four levels, 4 KiB page
    run_walk("R6",    EA3, 64'h0080_0000, 13, 52);                    // leaf at root
    run_walk("R7",    EA1 ^ 64'h0000_0000_0015_5555, 64'h0010_0000, 13, 52);
    run_walk("R2",    EA1, 64'h0010_0000, 4, 52);                     // root too narrow
    run_walk("R4",    EA1, 64'h0090_0000, 13, 52);                    // invalid at level two
    run_walk("R9",    EA1, 64'h00B0_0000, 13, 52);                    // narrow lower level
    run_walk("R10",   EA7, 64'h00D0_0000, 5, 64);                     // depth exceeded
    run_walk("R12",   EA1, 64'h0010_0000, 13, 10);                    // wider than space

    // R11: start while busy is ignored
    launch("R11", EA1, 64'h0010_0000, 13, 52);
    @(negedge clk);
    chk(busy_o == 1'b1, "R11", "busy during walk", 64'(busy_o), 64'd1);
    ea_i = EA2; root_base_i = 64'h0040_0000; root_lvl_bits_i = 5'd4;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    drain();
    repeat (10) @(negedge clk);
    chk(busy_o == 1'b0, "R11", "idle after walk", 64'(busy_o), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule